// File: doc/BRIEF.md
# Carrier-Sense Channel Access Controller

This block decides when a half-duplex powerline modem may begin sending a frame. A client raises a transmit request and holds it. The controller then picks one of seven listen windows at random, spaced 5 ms apart from 85 ms to 115 ms. The grant is given only if the qualified band-busy indication stays low for the whole window. When the band turns busy inside a window, that window is dropped at once and a new random window starts. The overall acquisition deadline keeps running through all of these retries.

The raw in-band detect from the analog front end is debounced inside the block. It counts as band busy only after 4 ms of continuous presence, and it stops counting the moment the raw detect falls. If no grant is reached before a programmable deadline, the attempt is abandoned and a sticky timeout interrupt is raised. The deadline is given in milliseconds and clamped to 1100 to 3000. While the interrupt is pending, new requests are refused. All timing is counted in cycles of the system clock, with `CLKS_PER_MS` cycles per millisecond.

Top module: `csma_access_ctrl`

## Requirements
- R1: Each listen window uses a code 0..6 that comes from a free-running LFSR. A draw of 7 is rejected and redrawn. The window length is 85 + 5*code ms. The code in use is shown on `win_code_o` while listening.
- R2: If `band_busy` stays low, `tx_grant` rises exactly (85 + 5*code)*CLKS_PER_MS cycles after the controller enters the listen state. It stays high for as long as `tx_req` is held. When `tx_req` drops, the block returns to idle on the next edge.
- R3: `band_busy` goes high only after `band_raw` has been sampled high on 4*CLKS_PER_MS consecutive clock edges. Any low sample restarts the count. `band_busy` falls in the same cycle that `band_raw` falls.
- R4: If `band_busy` is high during a listen window, the controller goes back to drawing on the next edge (`state_o` = 1). It then starts a fresh window, with `busy` staying high and no grant.
- R5: The deadline input is latched when a request is accepted and clamped to 1100..3000 ms. If no grant has occurred limit*CLKS_PER_MS cycles after acceptance, the block returns to idle, `busy` falls and `timeout_irq` rises.
- R6: `timeout_irq` stays high until a cycle with `irq_clr` high. It clears on the edge that follows.
- R7: While `timeout_irq` is high, `tx_req` is ignored: the state stays idle and `busy` stays low.
- R8: If `tx_req` is withdrawn during acquisition, the block returns to idle on the next edge with no grant and no interrupt.
- R9: After reset, `tx_grant`, `busy`, `timeout_irq` and `band_busy` are low and `state_o` is 0. The state codes are 0 idle, 1 drawing, 2 listening, 3 granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Transmit request, held until done |
| band_raw | input | 1 | Raw in-band signal detect |
| timeout_ms | input | TW (12) | Acquisition deadline in ms, clamped |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| tx_grant | output | 1 | Transmission may proceed |
| busy | output | 1 | Acquisition in progress |
| timeout_irq | output | 1 | Sticky acquisition timeout flag |
| band_busy | output | 1 | Qualified band-in-use indication |
| state_o | output | 2 | Controller state code |
| win_code_o | output | 3 | Current listen window code |

## Verification
The block's internal counters show up at the ports. A listen counter that is off by one moves the grant edge by a whole millisecond of cycles, and that shift appears as soon as the first window ends. A wrong qualification count makes `band_busy` rise one edge early or late, or rise after a broken burst. A deadline that is clamped or latched wrongly moves the interrupt edge by thousands of cycles, and a leaky interrupt flag lets a refused request leave idle within one cycle.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRAW   = 2'd1,
    ST_LISTEN = 2'd2,
    ST_GRANT  = 2'd3
  } csma_state_e;

  localparam int WIN_BASE_MS = 85;
  localparam int WIN_STEP_MS = 5;
  localparam logic [2:0] CODE_REJECT = 3'd7;

  // window length in ms for a window code 0..6
  function automatic logic [6:0] win_ms(input logic [2:0] code);
    return 7'(WIN_BASE_MS + WIN_STEP_MS * int'(code));
  endfunction
endpackage

// File: rtl/csma_ms_tick.sv
module csma_ms_tick #(
  parameter int CLKS_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + CW'(1);
  end

  assign tick = !clr && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: prescaler never runs past one millisecond
  a_r2_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/csma_band_qual.sv
module csma_band_qual #(
  parameter int QUAL_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic band_raw,
  output logic band_busy
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] FULL = QW'(QUAL_CYC);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          full;

  assign full = (cnt_q == FULL);

  always_comb begin
    if (!band_raw)  cnt_d = '0;
    else if (full)  cnt_d = cnt_q;
    else            cnt_d = cnt_q + QW'(1);
  end

  assign band_busy = band_raw && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the run counter saturates and never overshoots
  a_r3_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R3: a rise of band_busy is preceded by raw detect
  a_r3_rise_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(band_busy) |-> $past(band_raw));
endmodule

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    TAPS = 8'hB8,
  parameter logic [W-1:0]    SEED = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] rnd_o
);
  logic [W-1:0] q, d;

  always_comb begin
    d = q >> 1;
    if (q[0]) d = d ^ TAPS;
  end

  assign rnd_o = q[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= d;
  end

  // R1: the generator never locks up in the all-zero state
  a_r1_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
endmodule

// File: rtl/csma_access_ctrl.sv
module csma_access_ctrl
  import csma_pkg::*;
#(
  parameter int           CLKS_PER_MS = 50000,
  parameter int           QUAL_MS     = 4,
  parameter int           TMO_MIN_MS  = 1100,
  parameter int           TMO_MAX_MS  = 3000,
  parameter int           TW          = $clog2(TMO_MAX_MS + 1),
  parameter int           LFSR_W      = 8,
  parameter logic [7:0]   LFSR_TAPS   = 8'hB8,
  parameter logic [7:0]   LFSR_SEED   = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_req,
  input  logic          band_raw,
  input  logic [TW-1:0] timeout_ms,
  input  logic          irq_clr,
  output logic          tx_grant,
  output logic          busy,
  output logic          timeout_irq,
  output logic          band_busy,
  output logic [1:0]    state_o,
  output logic [2:0]    win_code_o
);
  localparam int QUAL_CYC = QUAL_MS * CLKS_PER_MS;
  localparam logic [TW-1:0] LIM_LO = TW'(TMO_MIN_MS);
  localparam logic [TW-1:0] LIM_HI = TW'(TMO_MAX_MS);

  csma_state_e   state_q, state_d;
  logic [2:0]    code_q, code_d;
  logic [6:0]    lcnt_q, lcnt_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [TW-1:0] lim_q, lim_d;
  logic          irq_q, irq_d, irq_set;
  logic          l_tick, t_tick;
  logic [2:0]    rnd;
  logic          start;

  function automatic logic [TW-1:0] clamp_lim(input logic [TW-1:0] v);
    if (v < LIM_LO)      return LIM_LO;
    else if (v > LIM_HI) return LIM_HI;
    else                 return v;
  endfunction

  csma_band_qual #(.QUAL_CYC(QUAL_CYC)) qual_i (
    .clk(clk), .rst_n(rst_n), .band_raw(band_raw), .band_busy(band_busy)
  );

  csma_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(LFSR_TAPS)), .SEED(LFSR_W'(LFSR_SEED))) lfsr_i (
    .clk(clk), .rst_n(rst_n), .rnd_o(rnd)
  );

  // listen prescaler restarts at every window entry
  csma_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) listen_tick_i (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_LISTEN), .tick(l_tick)
  );

  // deadline prescaler restarts at request acceptance only
  csma_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) tmo_tick_i (
    .clk(clk), .rst_n(rst_n), .clr(state_q == ST_IDLE), .tick(t_tick)
  );

  assign start = tx_req && !irq_q;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    lcnt_d  = lcnt_q;
    tcnt_d  = tcnt_q;
    lim_d   = lim_q;
    irq_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        lcnt_d = '0;
        tcnt_d = '0;
        if (start) begin
          lim_d   = clamp_lim(timeout_ms);
          state_d = ST_DRAW;
        end
      end
      ST_DRAW, ST_LISTEN: begin
        if (t_tick) tcnt_d = tcnt_q + TW'(1);
        if (!tx_req) begin
          state_d = ST_IDLE;
        end else if (t_tick && (tcnt_q == lim_q - TW'(1))) begin
          state_d = ST_IDLE;
          irq_set = 1'b1;
        end else if (state_q == ST_DRAW) begin
          if (rnd != CODE_REJECT) begin
            code_d  = rnd;
            lcnt_d  = '0;
            state_d = ST_LISTEN;
          end
        end else if (band_busy) begin
          state_d = ST_DRAW;
        end else if (l_tick) begin
          if (lcnt_q == win_ms(code_q) - 7'd1) state_d = ST_GRANT;
          else                                 lcnt_d  = lcnt_q + 7'd1;
        end
      end
      ST_GRANT: begin
        if (!tx_req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    irq_d = irq_set || (irq_q && !irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      lcnt_q  <= '0;
      tcnt_q  <= '0;
      lim_q   <= LIM_LO;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      lcnt_q  <= lcnt_d;
      tcnt_q  <= tcnt_d;
      lim_q   <= lim_d;
      irq_q   <= irq_d;
    end
  end

  assign tx_grant    = (state_q == ST_GRANT);
  assign busy        = (state_q == ST_DRAW) || (state_q == ST_LISTEN);
  assign timeout_irq = irq_q;
  assign state_o     = state_q;
  assign win_code_o  = code_q;

  // R1: a rejected code never reaches a listen window
  a_r1_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LISTEN) |-> (code_q != CODE_REJECT));
  // R2: grant follows a cycle in which the band was idle
  a_r2_grant_band_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_grant) |-> $past(!band_busy));
  // R4: busy band in a window sends the controller back to drawing
  a_r4_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LISTEN && band_busy && tx_req) |=> (state_q == ST_DRAW || state_q == ST_IDLE));
  // R5: the latched deadline stays inside the clamp range
  a_r5_lim_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lim_q >= LIM_LO && lim_q <= LIM_HI));
  // R6: interrupt persists without a clear
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_irq && !irq_clr) |=> timeout_irq);
  // R7: pending interrupt keeps the controller parked
  a_r7_irq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_irq |-> (!busy && !tx_grant));
endmodule

// File: tb/csma_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module csma_access_ctrl_tb_top;
  localparam int C  = 2;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tx_req, band_raw, irq_clr;
  logic [TW-1:0] timeout_ms;
  logic          tx_grant, busy, timeout_irq, band_busy;
  logic [1:0]    state_o;
  logic [2:0]    win_code_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  csma_access_ctrl #(.CLKS_PER_MS(C), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .band_raw(band_raw),
    .timeout_ms(timeout_ms), .irq_clr(irq_clr), .tx_grant(tx_grant),
    .busy(busy), .timeout_irq(timeout_irq), .band_busy(band_busy),
    .state_o(state_o), .win_code_o(win_code_o)
  );

  // deadline setting and the clamped limit it must produce (R5)
  localparam int NV = 5;
  localparam int TV_IN  [NV] = '{0, 1100, 2000, 3000, 4095};
  localparam int TV_EXP [NV] = '{1100, 1100, 2000, 3000, 3000};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_state(input int s, input string req);
    int k = 0;
    while (state_o != 2'(s) && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk(req, int'(state_o), s);
  endtask

  // request, then time the grant relative to listen entry (R1, R2)
  task automatic grant_run(input string req);
    int c0, code, k;
    wait_state(2, req);
    c0   = cyc;
    code = int'(win_code_o);
    n_chk++;
    if (code > 6) begin
      n_bad++;
      $display("FAIL R1: actual=%0d expected=0..6", code);
    end
    k = 0;
    while (!tx_grant && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk(req, cyc - c0, (85 + 5 * code) * C);
  endtask

  initial begin
    rst_n = 1'b0; tx_req = 1'b0; band_raw = 1'b0; irq_clr = 1'b0; timeout_ms = '0;
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9 grant", int'(tx_grant), 0);
    chk("R9 busy", int'(busy), 0);
    chk("R9 irq", int'(timeout_irq), 0);
    chk("R9 state", int'(state_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: deadline clamp and timeout edge (R5, R6, R7)
    for (int i = 0; i < NV; i++) begin
      band_raw   = 1'b1;
      timeout_ms = TW'(TV_IN[i]);
      repeat (10) @(negedge clk);
      tx_req = 1'b1;
      @(posedge clk);
      repeat (TV_EXP[i] * C - 1) @(posedge clk);
      @(negedge clk);
      chk("R5 irq before limit", int'(timeout_irq), 0);
      chk("R5 busy before limit", int'(busy), 1);
      @(posedge clk);
      @(negedge clk);
      chk("R5 irq at limit", int'(timeout_irq), 1);
      chk("R5 busy at limit", int'(busy), 0);
      repeat (20) @(negedge clk);
      chk("R6 irq sticky", int'(timeout_irq), 1);
      chk("R7 state parked", int'(state_o), 0);
      chk("R7 busy low", int'(busy), 0);
      tx_req  = 1'b0;
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R6 irq cleared", int'(timeout_irq), 0);
    end

    // R3: qualification of the raw detect
    band_raw = 1'b0;
    repeat (3) @(negedge clk);
    band_raw = 1'b1;
    repeat (4 * C - 1) @(posedge clk);
    @(negedge clk);
    chk("R3 not yet qualified", int'(band_busy), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 qualified", int'(band_busy), 1);
    band_raw = 1'b0;
    #1;
    chk("R3 immediate drop", int'(band_busy), 0);
    @(negedge clk);
    band_raw = 1'b1;
    repeat (4 * C - 1) @(negedge clk);
    band_raw = 1'b0;
    @(negedge clk);
    band_raw = 1'b1;
    repeat (4 * C - 1) @(negedge clk);
    chk("R3 broken burst", int'(band_busy), 0);
    band_raw = 1'b0;
    repeat (3) @(negedge clk);

    // R1, R2: several clean acquisitions with different windows
    timeout_ms = TW'(3000);
    for (int j = 0; j < 3; j++) begin
      tx_req = 1'b1;
      grant_run("R2 grant timing");
      repeat (20) @(negedge clk);
      chk("R2 grant held", int'(tx_grant), 1);
      tx_req = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R2 release", int'(state_o), 0);
      repeat (j + 3) @(negedge clk);
    end

    // R4: busy band aborts the window
    tx_req = 1'b1;
    wait_state(2, "R4 listen");
    band_raw = 1'b1;
    repeat (4 * C) @(negedge clk);
    chk("R4 busy seen in listen", int'(state_o), 2);
    @(posedge clk);
    @(negedge clk);
    chk("R4 back to draw", int'(state_o), 1);
    chk("R4 busy kept", int'(busy), 1);
    chk("R4 no grant", int'(tx_grant), 0);
    band_raw = 1'b0;
    grant_run("R4 fresh window");
    tx_req = 1'b0;
    repeat (4) @(negedge clk);

    // R8: withdrawn request
    tx_req = 1'b1;
    wait_state(2, "R8 listen");
    repeat (10) @(negedge clk);
    tx_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 idle", int'(state_o), 0);
    chk("R8 no grant", int'(tx_grant), 0);
    chk("R8 no irq", int'(timeout_irq), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule